// File: doc/BRIEF.md
# Oversampling UART with Multiprocessor Address Filter

This block is a full-duplex asynchronous serial port. A free-running divisor counter with a 12-bit reload value produces a sampling tick every `baud_div + 1` clock cycles. One serial bit lasts sixteen of these ticks. The receiver synchronises the `rxd` line and samples it on every tick. It confirms a start bit and votes each bit from three mid-bit samples. Each finished character goes into a one-entry output register. The transmitter holds one character in a holding register and a second in its shift register.

Received characters leave through a valid/ready stream (`rx_valid`, `rx_ready`). A character stays on `rx_data` until the consumer takes it. While it is unread, a newly finished character is dropped and `rx_overrun` is raised. Characters to send enter through a second valid/ready stream (`tx_valid`, `tx_ready`). `tx_ready` is high exactly when the holding register is empty. The holding register moves into the shift register only once the previous stop bit is fully on the line. With nine-bit frames and multiprocessor mode on, the receiver drops every frame whose ninth bit is 0. Software uses this to skip data meant for other stations until an address frame arrives.

Top module: `uart_mp_core`

## Requirements
- R1: A serial bit on `txd` lasts exactly 16 × (`baud_div` + 1) clock cycles.
- R2: After reset `txd` is 1, `tx_ready` and `tx_idle` are 1, and `rx_valid` and `rx_overrun` are 0. `txd` is 1 whenever `tx_idle` is 1.
- R3: With `nine_bit` = 0, a frame is received as a low start bit, eight data bits LSB first and a stop bit. The byte appears on `rx_data[7:0]` and `rx_data[8]` is 0.
- R4: With `nine_bit` = 1, a ninth data bit follows bit 7 and appears on `rx_data[8]`.
- R5: A low pulse on an idle `rxd` that ends before the sixth sample period of the would-be start bit is rejected as noise. No character is produced, and a frame that follows is received correctly.
- R6: Each bit is the majority of its samples 8, 9 and 10 (counting the start-detect sample as 1). An opposite level lasting one tick period at mid-bit does not change the received value.
- R7: `rx_ferr` travels with each character and is 1 exactly when that character's stop bit was voted low.
- R8: If a character finishes while `rx_valid` = 1 and `rx_ready` = 0, that character is discarded and `rx_overrun` is set. `rx_data` keeps the older character. `rx_overrun` clears only when a later character is placed in the output register.
- R9: With `mp_mode` = 1 and `nine_bit` = 1, frames with ninth bit 0 are dropped without any flag change. Frames with ninth bit 1 are delivered. With `mp_mode` = 0 all frames are delivered, and with `nine_bit` = 0 `mp_mode` has no effect.
- R10: A character accepted on the transmit stream is sent as a low start bit, data LSB first, the ninth bit when `nine_bit` = 1, and a high stop bit.
- R11: One character can be accepted while another is shifting. `tx_ready` is 0 in the cycle after an accept. The next character starts only after the previous stop bit has been sent completely. `tx_idle` is 1 only with both registers empty.
- R12: While `rx_valid` = 1 and `rx_ready` = 0, `rx_valid`, `rx_data` and `rx_ferr` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_div | input | 12 | Tick divisor; tick every baud_div+1 cycles |
| nine_bit | input | 1 | 1 selects nine data bits per frame |
| mp_mode | input | 1 | 1 drops nine-bit frames whose ninth bit is 0 |
| rxd | input | 1 | Serial receive line (asynchronous) |
| rx_data | output | 9 | Received character, bit 8 is the ninth bit |
| rx_ferr | output | 1 | Stop bit of this character was low |
| rx_valid | output | 1 | Received character available |
| rx_ready | input | 1 | Consumer takes the character |
| rx_overrun | output | 1 | A character was lost while the output was full |
| tx_data | input | 9 | Character to send, bit 8 used in nine-bit mode |
| tx_valid | input | 1 | Transmit character offered |
| tx_ready | output | 1 | Holding register empty, accepts a character |
| txd | output | 1 | Serial transmit line |
| tx_idle | output | 1 | Nothing held and nothing shifting |

## Verification
A received character is due at sample 10 of its stop bit. That is roughly 9.6 bit periods after the start edge for eight data bits, plus two synchroniser cycles and one register. The bench therefore checks `rx_valid`, `rx_data` and the flags only after it has driven the whole stop bit, which leaves about six sample periods of margin. Transmit bits change on tick boundaries. The bench decodes `txd` at mid-bit, eight ticks away from any edge, and measures one complete inner bit of a frame edge to edge to check the exact length 16 × (`baud_div` + 1). Back-pressure results (`tx_ready` low, `rx_valid` held) are sampled on the falling clock edge right after the accepting rising edge.

// File: rtl/uart_mp_pkg.sv
package uart_mp_pkg;
  localparam int unsigned CHAR_W = 9;
  localparam int unsigned SHIFT_W = CHAR_W + 2;

  typedef enum logic [1:0] {
    RXS_IDLE,
    RXS_START,
    RXS_DATA,
    RXS_STOP
  } rx_state_t;

  function automatic logic vote3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction
endpackage

// File: rtl/uart_mp_baud.sv
module uart_mp_baud #(
  parameter int unsigned DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (cnt == '0) cnt <= div;
    else cnt <= cnt - 1'b1;
  end

  assign tick = (cnt == '0);
endmodule

// File: rtl/uart_mp_rx_core.sv
module uart_mp_rx_core
  import uart_mp_pkg::*;
#(
  parameter int unsigned OVS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              nine,
  input  logic              rxd_async,
  output logic              done,
  output logic [CHAR_W-1:0] data,
  output logic              ferr
);
  // OVS must be a power of two so the sample counter wraps by itself.
  localparam int unsigned CW = $clog2(OVS);
  localparam logic [CW-1:0] V_A  = CW'(OVS / 2 - 1);
  localparam logic [CW-1:0] V_B  = CW'(OVS / 2);
  localparam logic [CW-1:0] V_C  = CW'(OVS / 2 + 1);
  localparam logic [CW-1:0] LAST = CW'(OVS - 1);

  logic              sy1, sy2;
  rx_state_t         st;
  logic [CW-1:0]     scnt;
  logic [CW-1:0]     nxt;
  logic [3:0]        bcnt;
  logic [1:0]        votes;
  logic [CHAR_W-1:0] sh;
  logic              maj;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy1 <= 1'b1;
      sy2 <= 1'b1;
    end else begin
      sy1 <= rxd_async;
      sy2 <= sy1;
    end
  end

  assign nxt = scnt + 1'b1;
  assign maj = vote3(votes[0], votes[1], sy2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= RXS_IDLE;
      scnt  <= '0;
      bcnt  <= '0;
      votes <= '0;
      sh    <= '0;
      done  <= 1'b0;
      data  <= '0;
      ferr  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (tick) begin
        if (st == RXS_IDLE) begin
          if (!sy2) begin
            st   <= RXS_START;
            scnt <= '0;
          end
        end else begin
          scnt <= nxt;
          if (nxt == V_A) votes[0] <= sy2;
          if (nxt == V_B) votes[1] <= sy2;
          if (nxt == V_C) begin
            case (st)
              RXS_START: if (maj) st <= RXS_IDLE;
              RXS_DATA:  sh <= {maj, sh[CHAR_W-1:1]};
              RXS_STOP: begin
                done <= 1'b1;
                ferr <= ~maj;
                data <= nine ? sh : {1'b0, sh[CHAR_W-1:1]};
                st   <= RXS_IDLE;
              end
              default: st <= RXS_IDLE;
            endcase
          end
          if (nxt == LAST) begin
            if (st == RXS_START) begin
              st   <= RXS_DATA;
              bcnt <= '0;
            end else if (st == RXS_DATA) begin
              if (bcnt == (nine ? 4'd8 : 4'd7)) st <= RXS_STOP;
              else bcnt <= bcnt + 1'b1;
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/uart_mp_rx_buf.sv
module uart_mp_rx_buf
  import uart_mp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done,
  input  logic [CHAR_W-1:0] data,
  input  logic              ferr,
  input  logic              nine,
  input  logic              mp_mode,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [CHAR_W-1:0] out_data,
  output logic              out_ferr,
  output logic              overrun
);
  logic drop;

  assign drop = mp_mode & nine & ~data[CHAR_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_ferr  <= 1'b0;
      overrun   <= 1'b0;
    end else begin
      if (out_valid && out_ready) out_valid <= 1'b0;
      if (done && !drop) begin
        if (out_valid && !out_ready) begin
          overrun <= 1'b1;
        end else begin
          out_valid <= 1'b1;
          out_data  <= data;
          out_ferr  <= ferr;
          overrun   <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/uart_mp_tx_core.sv
module uart_mp_tx_core
  import uart_mp_pkg::*;
#(
  parameter int unsigned OVS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              nine,
  input  logic              in_valid,
  input  logic [CHAR_W-1:0] in_data,
  output logic              in_ready,
  output logic              txd,
  output logic              idle
);
  localparam int unsigned CW = $clog2(OVS);
  localparam logic [CW-1:0] LAST = CW'(OVS - 1);

  logic [CHAR_W-1:0]  hold;
  logic               hold_full;
  logic [SHIFT_W-1:0] sh;
  logic [3:0]         left;
  logic [CW-1:0]      tcnt;
  logic               busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold      <= '0;
      hold_full <= 1'b0;
      sh        <= '1;
      left      <= '0;
      tcnt      <= '0;
      busy      <= 1'b0;
    end else begin
      if (in_valid && !hold_full) begin
        hold      <= in_data;
        hold_full <= 1'b1;
      end
      if (!busy && hold_full) begin
        sh        <= {1'b1, (nine ? hold[CHAR_W-1] : 1'b1), hold[7:0], 1'b0};
        left      <= nine ? 4'd11 : 4'd10;
        tcnt      <= '0;
        busy      <= 1'b1;
        hold_full <= 1'b0;
      end else if (busy && tick) begin
        if (tcnt == LAST) begin
          tcnt <= '0;
          sh   <= {1'b1, sh[SHIFT_W-1:1]};
          left <= left - 1'b1;
          if (left == 4'd1) busy <= 1'b0;
        end else begin
          tcnt <= tcnt + 1'b1;
        end
      end
    end
  end

  assign in_ready = ~hold_full;
  assign txd      = busy ? sh[0] : 1'b1;
  assign idle     = ~busy & ~hold_full;
endmodule

// File: rtl/uart_mp_core.sv
module uart_mp_core
  import uart_mp_pkg::*;
#(
  parameter int unsigned DIV_W = 12,
  parameter int unsigned OVS   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  baud_div,
  input  logic              nine_bit,
  input  logic              mp_mode,
  input  logic              rxd,
  output logic [CHAR_W-1:0] rx_data,
  output logic              rx_ferr,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic              rx_overrun,
  input  logic [CHAR_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic              txd,
  output logic              tx_idle
);
  logic              tick;
  logic              fr_done;
  logic [CHAR_W-1:0] fr_data;
  logic              fr_ferr;

  uart_mp_baud #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst_n(rst_n), .div(baud_div), .tick(tick)
  );

  uart_mp_rx_core #(.OVS(OVS)) u_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .nine(nine_bit), .rxd_async(rxd),
    .done(fr_done), .data(fr_data), .ferr(fr_ferr)
  );

  uart_mp_rx_buf u_rxbuf (
    .clk(clk), .rst_n(rst_n), .done(fr_done), .data(fr_data), .ferr(fr_ferr),
    .nine(nine_bit), .mp_mode(mp_mode), .out_ready(rx_ready),
    .out_valid(rx_valid), .out_data(rx_data), .out_ferr(rx_ferr),
    .overrun(rx_overrun)
  );

  uart_mp_tx_core #(.OVS(OVS)) u_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .nine(nine_bit),
    .in_valid(tx_valid), .in_data(tx_data), .in_ready(tx_ready),
    .txd(txd), .idle(tx_idle)
  );
endmodule

// File: rtl/uart_mp_sva.sv
module uart_mp_sva (
  input logic       clk,
  input logic       rst_n,
  input logic [8:0] rx_data,
  input logic       rx_ferr,
  input logic       rx_valid,
  input logic       rx_ready,
  input logic       rx_overrun,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic       txd,
  input logic       tx_idle
);
  p_hold_stable_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data) && $stable(rx_ferr)));

  p_overrun_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_overrun) |-> $past(rx_valid && !rx_ready));

  p_tx_accept_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_ready);

  p_idle_line_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_idle |-> txd);

  p_idle_ready_r11: assert property (@(posedge clk) disable iff (!rst_n)
    tx_idle |-> tx_ready);
endmodule

bind uart_mp_core uart_mp_sva u_sva (
  .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_ferr(rx_ferr),
  .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_overrun(rx_overrun),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .txd(txd), .tx_idle(tx_idle)
);

// File: tb/uart_mp_core_test.sv
module uart_mp_core_test;
  localparam int DIV = 3;
  localparam int T   = DIV + 1;
  localparam int BIT = 16 * T;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] baud_div = 12'(DIV);
  logic        nine_bit = 1'b0;
  logic        mp_mode = 1'b0;
  logic        rxd = 1'b1;
  logic [8:0]  rx_data;
  logic        rx_ferr, rx_valid, rx_overrun;
  logic        rx_ready = 1'b0;
  logic [8:0]  tx_data = '0;
  logic        tx_valid = 1'b0;
  logic        tx_ready, txd, tx_idle;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  uart_mp_core uut (
    .clk(clk), .rst_n(rst_n), .baud_div(baud_div), .nine_bit(nine_bit),
    .mp_mode(mp_mode), .rxd(rxd), .rx_data(rx_data), .rx_ferr(rx_ferr),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_overrun(rx_overrun),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .txd(txd), .tx_idle(tx_idle)
  );

  function automatic logic [8:0] expect_char(logic [8:0] d, bit nb);
    return nb ? d : {1'b0, d[7:0]};
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive_bit(logic v, bit glitch);
    rxd = v;
    if (glitch) begin
      repeat (8 * T) @(negedge clk);
      rxd = ~v;
      repeat (T) @(negedge clk);
      rxd = v;
      repeat (7 * T) @(negedge clk);
    end else begin
      repeat (BIT) @(negedge clk);
    end
  endtask

  // gbit: 0 none, 1 start bit, 2..10 data bit gbit-2
  task automatic send_frame(logic [8:0] d, bit nb, logic stopv, int gbit);
    drive_bit(1'b0, gbit == 1);
    for (int i = 0; i < (nb ? 9 : 8); i++) drive_bit(d[i], gbit == i + 2);
    drive_bit(stopv, 1'b0);
    rxd = 1'b1;
  endtask

  task automatic pop_check(logic [8:0] exp, logic ef, string tag);
    chk(rx_valid == 1'b1, tag, int'(rx_valid), 1);
    chk(rx_data == exp, tag, int'(rx_data), int'(exp));
    chk(rx_ferr == ef, tag, int'(rx_ferr), int'(ef));
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
    chk(rx_valid == 1'b0, tag, int'(rx_valid), 0);
  endtask

  task automatic tx_push(logic [8:0] d);
    @(negedge clk);
    while (!tx_ready) @(negedge clk);
    tx_data  = d;
    tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic tx_grab(bit nb, output logic [8:0] d, output bit ok);
    d = '0;
    @(negedge txd);
    repeat (8 * T) @(posedge clk);
    ok = (txd == 1'b0);
    for (int i = 0; i < (nb ? 9 : 8); i++) begin
      repeat (BIT) @(posedge clk);
      d[i] = txd;
    end
    repeat (BIT) @(posedge clk);
    ok = ok && (txd == 1'b1);
  endtask

  task automatic tx_round(logic [8:0] d, bit nb, string tag);
    logic [8:0] got;
    bit ok;
    nine_bit = nb;
    fork
      tx_grab(nb, got, ok);
      tx_push(d);
    join
    chk(ok, tag, int'(ok), 1);
    chk(got == expect_char(d, nb), tag, int'(got), int'(expect_char(d, nb)));
  endtask

  task automatic measure_bit(int dv);
    int n;
    baud_div = 12'(dv);
    repeat (4 * (dv + 1)) @(negedge clk);
    nine_bit = 1'b0;
    tx_push(9'h001);
    @(posedge txd);
    n = 0;
    while (txd) begin
      @(posedge clk);
      #1;
      n++;
    end
    chk(n == 16 * (dv + 1), "R1 bit length", n, 16 * (dv + 1));
    repeat (16 * (dv + 1) * 10) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [8:0] d, a, b, ga, gb;
    bit nb, oka, okb;
    void'($urandom(32'd1234));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R2 reset state
    chk(txd == 1'b1, "R2 txd", int'(txd), 1);
    chk(tx_ready && tx_idle, "R2 tx flags", int'({tx_ready, tx_idle}), 3);
    chk(!rx_valid && !rx_overrun, "R2 rx flags", int'({rx_valid, rx_overrun}), 0);
    repeat (BIT) @(negedge clk);

    // R3 directed eight-bit frame
    send_frame(9'h0A5, 1'b0, 1'b1, 0);
    pop_check(9'h0A5, 1'b0, "R3 byte");
    // R4 nine-bit frame with ninth bit set
    nine_bit = 1'b1;
    send_frame(9'h13C, 1'b1, 1'b1, 0);
    pop_check(9'h13C, 1'b0, "R4 ninth bit");

    // R5 short low pulse rejected, then a frame decodes
    nine_bit = 1'b0;
    rxd = 1'b0;
    repeat (3 * T) @(negedge clk);
    rxd = 1'b1;
    repeat (12 * BIT) @(negedge clk);
    chk(rx_valid == 1'b0, "R5 noise", int'(rx_valid), 0);
    send_frame(9'h03C, 1'b0, 1'b1, 0);
    pop_check(9'h03C, 1'b0, "R5 after noise");

    // R6 one-tick glitches at mid-bit
    send_frame(9'h0F0, 1'b0, 1'b1, 1);
    pop_check(9'h0F0, 1'b0, "R6 start glitch");
    send_frame(9'h0F0, 1'b0, 1'b1, 4);
    pop_check(9'h0F0, 1'b0, "R6 data glitch low");
    send_frame(9'h0F0, 1'b0, 1'b1, 7);
    pop_check(9'h0F0, 1'b0, "R6 data glitch high");

    // R7 framing error
    send_frame(9'h055, 1'b0, 1'b0, 0);
    pop_check(9'h055, 1'b1, "R7 low stop");
    repeat (BIT) @(negedge clk);
    chk(rx_valid == 1'b0, "R7 no false char", int'(rx_valid), 0);

    // R8 overrun
    send_frame(9'h011, 1'b0, 1'b1, 0);
    send_frame(9'h022, 1'b0, 1'b1, 0);
    chk(rx_overrun == 1'b1, "R8 overrun set", int'(rx_overrun), 1);
    pop_check(9'h011, 1'b0, "R8 older kept");
    chk(rx_overrun == 1'b1, "R8 overrun sticky", int'(rx_overrun), 1);
    send_frame(9'h033, 1'b0, 1'b1, 0);
    chk(rx_overrun == 1'b0, "R8 overrun cleared", int'(rx_overrun), 0);
    pop_check(9'h033, 1'b0, "R8 next char");

    // R9 multiprocessor filtering
    nine_bit = 1'b1;
    mp_mode  = 1'b1;
    send_frame(9'h044, 1'b1, 1'b1, 0);
    chk(rx_valid == 1'b0, "R9 data frame dropped", int'(rx_valid), 0);
    chk(rx_overrun == 1'b0, "R9 no flag", int'(rx_overrun), 0);
    send_frame(9'h1A7, 1'b1, 1'b1, 0);
    pop_check(9'h1A7, 1'b0, "R9 address delivered");
    mp_mode = 1'b0;
    send_frame(9'h044, 1'b1, 1'b1, 0);
    pop_check(9'h044, 1'b0, "R9 normal resumed");
    nine_bit = 1'b0;
    mp_mode  = 1'b1;
    send_frame(9'h066, 1'b0, 1'b1, 0);
    pop_check(9'h066, 1'b0, "R9 eight-bit unaffected");
    mp_mode = 1'b0;

    // R3 R4 random received frames, R12 hold before pop
    for (int k = 0; k < 10; k++) begin
      nb = 1'($urandom_range(0, 1));
      d = 9'($urandom);
      nine_bit = nb;
      send_frame(d, nb, 1'b1, 0);
      repeat (20) @(negedge clk);
      pop_check(expect_char(d, nb), 1'b0, "R12 R3 R4 random rx");
    end

    // R10 transmit frames
    tx_round(9'h0C3, 1'b0, "R10 tx byte");
    tx_round(9'h15A, 1'b1, "R10 tx nine");
    for (int k = 0; k < 6; k++) begin
      nb = 1'($urandom_range(0, 1));
      tx_round(9'($urandom), nb, "R10 tx random");
    end

    // R11 back-to-back transmit
    nine_bit = 1'b0;
    a = 9'h081;
    b = 9'h07E;
    repeat (BIT) @(negedge clk);
    fork
      begin
        tx_grab(1'b0, ga, oka);
        tx_grab(1'b0, gb, okb);
      end
      begin
        tx_push(a);
        tx_push(b);
        chk(tx_ready == 1'b0, "R11 holding full", int'(tx_ready), 0);
        chk(tx_idle == 1'b0, "R11 not idle", int'(tx_idle), 0);
      end
    join
    chk(oka && okb, "R11 framing", int'({oka, okb}), 3);
    chk(ga == a, "R11 first", int'(ga), int'(a));
    chk(gb == b, "R11 second", int'(gb), int'(b));
    repeat (BIT) @(negedge clk);
    chk(tx_idle && txd, "R11 R2 idle after", int'({tx_idle, txd}), 3);

    // R1 bit length at two divisors
    measure_bit(3);
    measure_bit(6);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule